// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block owns a small set of outgoing message slots and decides which one goes out next. Each slot carries a 4-bit state. The states of all slots are packed into one status word. Software moves slots between states with a command strobe. The strobe carries a slot-select mask and three action bits: mark ready, abort and release to empty. A separate priority word gives each slot a 3-bit priority.

Whenever the scheduler is enabled and has nothing in flight, it picks a ready slot and hands its index to a frame sender. The pick goes to the slot with the strictly highest nonzero priority, and among equal priorities to the lowest index. The sender returns a completion that reports success or failure. The scheduler then records the outcome, counts successful frames, pulses its interrupt events and picks again. This repeats until no eligible slot is left.

The request to the sender uses valid/ready. `tx_valid` rises together with a stable `tx_idx`, and both hold until the sender raises `tx_ready`. The sender may keep `tx_ready` low for as long as it likes. After acceptance the block stays busy until `tx_done` arrives. The completion is a plain one-cycle pulse with no back-pressure. Command, priority and status pins are plain level or strobe signals.

Top module: `txbuf_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every slot is empty. `status_word` is 0, `tx_frame_cnt` is 0, `tx_valid`, `busy`, `irq_tx_done` and `irq_buf_chg` are 0, and `txnf` is 1.
- R2: Slot i reports its state in `status_word[4i+3:4i]`. The codes are 0 empty, 1 ready, 2 sent OK, 3 failed and 4 aborted.
- R3: A command (`cmd_valid` high for one cycle) changes only the slots whose bit is set in `cmd_sel`. The change is visible in the following cycle. While `enable` is low the command changes nothing.
- R4: For each selected slot, the three actions are evaluated in a fixed order: abort first, then mark ready, then release. Abort turns ready into aborted and nothing else. Mark ready turns empty, sent OK, failed or aborted into ready. Release turns sent OK, failed or aborted into empty.
- R5: The priority of slot i is `prio_word[4i+2:4i]`, and bit 4i+3 is ignored. Among ready slots, the pick is the one whose priority is strictly greater than that of every lower-indexed ready slot and at least that of every higher-indexed one. In other words, the highest priority wins and ties go to the lowest index.
- R6: A ready slot whose priority is 0 is never requested. No request is issued while `enable` is low.
- R7: Once `tx_valid` is high, it stays high with `tx_idx` unchanged until a cycle with `tx_ready` high. `busy` is high from the issue until the completion, and no new request is issued while `busy` is high.
- R8: A `tx_done` pulse after the request was accepted completes the transfer. With `tx_ok`=1 the slot becomes sent OK, `tx_frame_cnt` increments, and `irq_tx_done` and `irq_buf_chg` both pulse for one cycle. With `tx_ok`=0 the slot becomes failed, the counter holds, and only `irq_buf_chg` pulses. A `tx_done` pulse with no accepted request outstanding has no effect.
- R9: `txnf` is 1 exactly when at least one slot is empty.
- R10: After each completion the scheduler picks again, until no ready slot with nonzero priority remains.
- R11: When a completion and a command hit the same slot in the same cycle, the completion outcome is what the slot takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enabled; gates commands and new requests |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | NUM_BUFS | Slot-select mask of the command |
| cmd_set_ready | input | 1 | Action: mark ready |
| cmd_abort | input | 1 | Action: abort |
| cmd_set_empty | input | 1 | Action: release to empty |
| prio_we | input | 1 | Priority word write strobe |
| prio_wdata | input | 4*NUM_BUFS | New priority word |
| prio_word | output | 4*NUM_BUFS | Current priority word |
| tx_valid | output | 1 | Request to the frame sender |
| tx_ready | input | 1 | Sender accepts the request |
| tx_idx | output | log2(NUM_BUFS) | Slot index carried by the request |
| tx_done | input | 1 | Completion pulse from the sender |
| tx_ok | input | 1 | Completion outcome, 1 = success |
| busy | output | 1 | A request is in flight |
| status_word | output | 4*NUM_BUFS | Packed slot states |
| txnf | output | 1 | At least one slot is empty |
| tx_frame_cnt | output | CNT_W | Count of successful frames |
| irq_tx_done | output | 1 | One-cycle pulse on a successful completion |
| irq_buf_chg | output | 1 | One-cycle pulse on any completion |

## Verification
The bench uses the default build: four slots, a 3-bit priority and a 16-bit frame counter. At this size every slot can be driven through every reachable state and hit with all eight action combinations, both enabled and disabled. That gives the whole state-by-command table. One priority word in five of the 4096 combinations is also replayed with all slots ready. This covers ties, zero priorities and the full serving order of each word, together with back-pressure from the sender and the completion-versus-command collision.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [FIELD_W-1:0] {
    BST_EMPTY   = 4'd0,
    BST_READY   = 4'd1,
    BST_SENT_OK = 4'd2,
    BST_FAILED  = 4'd3,
    BST_ABORTED = 4'd4
  } buf_state_e;
endpackage

// File: rtl/txbuf_slot.sv
module txbuf_slot
  import txbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_hit,
  input  logic       do_ready,
  input  logic       do_abort,
  input  logic       do_empty,
  input  logic       done_hit,
  input  logic       done_ok,
  output buf_state_e state
);
  buf_state_e after_cmd;
  buf_state_e state_nxt;

  // Actions applied in sequence: abort, mark ready, release.
  always_comb begin
    after_cmd = state;
    if (do_abort && after_cmd == BST_READY) begin
      after_cmd = BST_ABORTED;
    end
    if (do_ready) begin
      case (after_cmd)
        BST_EMPTY, BST_SENT_OK, BST_FAILED, BST_ABORTED: after_cmd = BST_READY;
        default: ;
      endcase
    end
    if (do_empty) begin
      case (after_cmd)
        BST_SENT_OK, BST_FAILED, BST_ABORTED: after_cmd = BST_EMPTY;
        default: ;
      endcase
    end
  end

  always_comb begin
    state_nxt = state;
    if (cmd_hit) begin
      state_nxt = after_cmd;
    end
    // Completion outcome overrides a coincident command.
    if (done_hit) begin
      state_nxt = done_ok ? BST_SENT_OK : BST_FAILED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= BST_EMPTY;
    end else begin
      state <= state_nxt;
    end
  end
endmodule

// File: rtl/txbuf_arbiter.sv
module txbuf_arbiter
  import txbuf_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int PRIO_W   = 3,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic [NUM_BUFS-1:0]         ready_vec,
  input  logic [NUM_BUFS*FIELD_W-1:0] prio_flat,
  output logic                        found,
  output logic [IDX_W-1:0]            pick_idx
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with a strict compare: ties keep the lower index,
  // and starting at zero means priority 0 can never win.
  always_comb begin
    best     = '0;
    found    = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NUM_BUFS; i++) begin
      if (ready_vec[i] && (prio_flat[i*FIELD_W +: PRIO_W] > best)) begin
        best     = prio_flat[i*FIELD_W +: PRIO_W];
        found    = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/txbuf_issue.sv
module txbuf_issue #(
  parameter int NUM_BUFS = 4,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             found,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             tx_ready,
  input  logic             tx_done,
  input  logic             tx_ok,
  output logic             tx_valid,
  output logic [IDX_W-1:0] tx_idx,
  output logic             busy,
  output logic             done_fire,
  output logic [CNT_W-1:0] tx_frame_cnt,
  output logic             irq_tx_done,
  output logic             irq_buf_chg
);
  logic issue;

  assign issue     = enable && found && !busy;
  // A completion counts only once the request has been accepted.
  assign done_fire = tx_done && busy && !tx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid     <= 1'b0;
      tx_idx       <= '0;
      busy         <= 1'b0;
      tx_frame_cnt <= '0;
      irq_tx_done  <= 1'b0;
      irq_buf_chg  <= 1'b0;
    end else begin
      if (issue) begin
        tx_valid <= 1'b1;
        tx_idx   <= pick_idx;
        busy     <= 1'b1;
      end else if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (done_fire) begin
        busy <= 1'b0;
        if (tx_ok) begin
          tx_frame_cnt <= tx_frame_cnt + CNT_W'(1);
        end
      end
      irq_tx_done <= done_fire && tx_ok;
      irq_buf_chg <= done_fire;
    end
  end
endmodule

// File: rtl/txbuf_sched.sv
module txbuf_sched
  import txbuf_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int PRIO_W   = 3,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int WORD_W  = NUM_BUFS * FIELD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cmd_valid,
  input  logic [NUM_BUFS-1:0] cmd_sel,
  input  logic                cmd_set_ready,
  input  logic                cmd_abort,
  input  logic                cmd_set_empty,
  input  logic                prio_we,
  input  logic [WORD_W-1:0]   prio_wdata,
  output logic [WORD_W-1:0]   prio_word,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [IDX_W-1:0]    tx_idx,
  input  logic                tx_done,
  input  logic                tx_ok,
  output logic                busy,
  output logic [WORD_W-1:0]   status_word,
  output logic                txnf,
  output logic [CNT_W-1:0]    tx_frame_cnt,
  output logic                irq_tx_done,
  output logic                irq_buf_chg
);
  buf_state_e            slot_st [NUM_BUFS];
  logic [NUM_BUFS-1:0]   ready_vec;
  logic [NUM_BUFS-1:0]   empty_vec;
  logic                  found;
  logic [IDX_W-1:0]      pick_idx;
  logic                  done_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_word <= '0;
    end else if (prio_we) begin
      prio_word <= prio_wdata;
    end
  end

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
    logic hit;
    logic dhit;
    assign hit  = cmd_valid && enable && cmd_sel[g];
    assign dhit = done_fire && (tx_idx == IDX_W'(g));

    txbuf_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_hit  (hit),
      .do_ready (cmd_set_ready),
      .do_abort (cmd_abort),
      .do_empty (cmd_set_empty),
      .done_hit (dhit),
      .done_ok  (tx_ok),
      .state    (slot_st[g])
    );

    assign status_word[g*FIELD_W +: FIELD_W] = slot_st[g];
    assign ready_vec[g] = (slot_st[g] == BST_READY);
    assign empty_vec[g] = (slot_st[g] == BST_EMPTY);
  end

  assign txnf = |empty_vec;

  txbuf_arbiter #(
    .NUM_BUFS (NUM_BUFS),
    .PRIO_W   (PRIO_W)
  ) u_arb (
    .ready_vec (ready_vec),
    .prio_flat (prio_word),
    .found     (found),
    .pick_idx  (pick_idx)
  );

  txbuf_issue #(
    .NUM_BUFS (NUM_BUFS),
    .CNT_W    (CNT_W)
  ) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .found        (found),
    .pick_idx     (pick_idx),
    .tx_ready     (tx_ready),
    .tx_done      (tx_done),
    .tx_ok        (tx_ok),
    .tx_valid     (tx_valid),
    .tx_idx       (tx_idx),
    .busy         (busy),
    .done_fire    (done_fire),
    .tx_frame_cnt (tx_frame_cnt),
    .irq_tx_done  (irq_tx_done),
    .irq_buf_chg  (irq_buf_chg)
  );
endmodule

// File: rtl/txbuf_sched_chk.sv
module txbuf_sched_chk #(
  parameter int NUM_BUFS = 4,
  parameter int PRIO_W   = 3,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int WORD_W  = NUM_BUFS * 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              busy,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [IDX_W-1:0]  tx_idx,
  input logic [WORD_W-1:0] prio_word,
  input logic [WORD_W-1:0] status_word,
  input logic [CNT_W-1:0]  tx_frame_cnt,
  input logic              irq_tx_done,
  input logic              irq_buf_chg
);
  logic [WORD_W-1:0] prio_q;
  logic [WORD_W-1:0] stat_q;
  logic [PRIO_W-1:0] picked_prio;
  logic [3:0]        picked_state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      stat_q <= '0;
    end else begin
      prio_q <= prio_word;
      stat_q <= status_word;
    end
  end

  assign picked_prio  = prio_q[tx_idx*4 +: PRIO_W];
  assign picked_state = stat_q[tx_idx*4 +: 4];

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_idx)); // R7
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_valid |=> !tx_valid); // R7
  AST_PICK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> picked_prio != '0); // R6
  AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> picked_state == 4'd1); // R5
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !busy |=> $stable(status_word)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_frame_cnt == $past(tx_frame_cnt)) ||
             (tx_frame_cnt == $past(tx_frame_cnt) + CNT_W'(1))); // R8
  AST_CNT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_done |-> tx_frame_cnt == $past(tx_frame_cnt) + CNT_W'(1)); // R8
  AST_IRQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_done |-> irq_buf_chg); // R8
endmodule

bind txbuf_sched txbuf_sched_chk #(
  .NUM_BUFS (NUM_BUFS),
  .PRIO_W   (PRIO_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .busy         (busy),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_idx       (tx_idx),
  .prio_word    (prio_word),
  .status_word  (status_word),
  .tx_frame_cnt (tx_frame_cnt),
  .irq_tx_done  (irq_tx_done),
  .irq_buf_chg  (irq_buf_chg)
);

// File: tb/test_txbuf_sched.sv
module test_txbuf_sched;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_sel = '0;
  logic        cmd_set_ready = 1'b0;
  logic        cmd_abort = 1'b0;
  logic        cmd_set_empty = 1'b0;
  logic        prio_we = 1'b0;
  logic [15:0] prio_wdata = '0;
  logic [15:0] prio_word;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [1:0]  tx_idx;
  logic        tx_done = 1'b0;
  logic        tx_ok = 1'b0;
  logic        busy;
  logic [15:0] status_word;
  logic        txnf;
  logic [15:0] tx_frame_cnt;
  logic        irq_tx_done;
  logic        irq_buf_chg;

  int total = 0;
  int bad = 0;
  int exp_st [NB];
  int exp_cnt = 0;
  int cur_pr [NB];

  always #5 clk = ~clk;

  txbuf_sched i_txbuf_sched (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_set_ready(cmd_set_ready),
    .cmd_abort(cmd_abort), .cmd_set_empty(cmd_set_empty),
    .prio_we(prio_we), .prio_wdata(prio_wdata), .prio_word(prio_word),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
    .tx_done(tx_done), .tx_ok(tx_ok), .busy(busy),
    .status_word(status_word), .txnf(txnf), .tx_frame_cnt(tx_frame_cnt),
    .irq_tx_done(irq_tx_done), .irq_buf_chg(irq_buf_chg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 model of one slot under the three ordered actions.
  function automatic int next_st(input int s, input logic r, input logic a, input logic e);
    int t = s;
    if (a && t == 1) t = 4;
    if (r && (t == 0 || t == 2 || t == 3 || t == 4)) t = 1;
    if (e && (t == 2 || t == 3 || t == 4)) t = 0;
    return t;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int i = 0; i < NB; i++) w[i*4 +: 4] = 4'(exp_st[i]);
    return w;
  endfunction

  function automatic logic exp_nf();
    logic f = 1'b0;
    for (int i = 0; i < NB; i++) if (exp_st[i] == 0) f = 1'b1;
    return f;
  endfunction

  task automatic check_status(input string req);
    check({req, " status R2"}, status_word, exp_word());
    check("R9 txnf", txnf, exp_nf());
  endtask

  task automatic send_cmd(input logic [3:0] sel, input logic r, input logic a, input logic e);
    cmd_valid = 1'b1; cmd_sel = sel;
    cmd_set_ready = r; cmd_abort = a; cmd_set_empty = e;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sel = '0;
    cmd_set_ready = 1'b0; cmd_abort = 1'b0; cmd_set_empty = 1'b0;
  endtask

  task automatic write_prio(input logic [15:0] w);
    prio_we = 1'b1; prio_wdata = w;
    @(negedge clk);
    prio_we = 1'b0;
    for (int i = 0; i < NB; i++) cur_pr[i] = int'(w[i*4 +: 3]);
  endtask

  // Serve one request from the sender side; with_cmd collides a command.
  task automatic serve(input int b, input logic ok, input logic with_cmd);
    int w = 0;
    while (!tx_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    check("R7 request issued", tx_valid, 1);
    check("R5 winner index", tx_idx, b);
    check("R7 busy on issue", busy, 1);
    @(negedge clk);
    check("R7 request held", tx_valid, 1);
    check("R7 index held", tx_idx, b);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check("R7 accepted", tx_valid, 0);
    check("R7 busy after accept", busy, 1);
    tx_done = 1'b1; tx_ok = ok;
    if (with_cmd) begin
      cmd_valid = 1'b1; cmd_sel = 4'(1 << b);
      cmd_abort = 1'b1; cmd_set_empty = 1'b1;
    end
    @(negedge clk);
    tx_done = 1'b0; tx_ok = 1'b0;
    cmd_valid = 1'b0; cmd_sel = '0; cmd_abort = 1'b0; cmd_set_empty = 1'b0;
    exp_st[b] = ok ? 2 : 3;
    if (ok) exp_cnt++;
    check("R8 irq_tx_done", irq_tx_done, ok);
    check("R8 irq_buf_chg", irq_buf_chg, 1);
    check("R8 frame count", tx_frame_cnt, exp_cnt);
    check_status(with_cmd ? "R11" : "R8");
    @(negedge clk);
    check("R8 irq pulse ends", {irq_tx_done, irq_buf_chg}, 0);
  endtask

  task automatic drive_to(input int b, input int s);
    logic [3:0] sel = 4'(1 << b);
    send_cmd(sel, 1'b0, 1'b1, 1'b1);
    exp_st[b] = 0;
    case (s)
      1: begin send_cmd(sel, 1'b1, 1'b0, 1'b0); exp_st[b] = 1; end
      4: begin
        send_cmd(sel, 1'b1, 1'b0, 1'b0);
        send_cmd(sel, 1'b0, 1'b1, 1'b0);
        exp_st[b] = 4;
      end
      2, 3: begin
        write_prio(16'(7 << (4*b)));
        send_cmd(sel, 1'b1, 1'b0, 1'b0);
        exp_st[b] = 1;
        serve(b, s == 2, 1'b0);
        write_prio(16'h0);
      end
      default: ;
    endcase
  endtask

  function automatic int model_pick();
    int best = 0;
    int w = -1;
    for (int i = 0; i < NB; i++)
      if (exp_st[i] == 1 && cur_pr[i] > best) begin
        best = cur_pr[i];
        w = i;
      end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin exp_st[i] = 0; cur_pr[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 status in reset", status_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", status_word, 0);
    check("R1 txnf", txnf, 1);
    check("R1 counter", tx_frame_cnt, 0);
    check("R1 request", {tx_valid, busy}, 0);
    check("R1 irqs", {irq_tx_done, irq_buf_chg}, 0);

    // R8: a completion with nothing outstanding is ignored.
    tx_done = 1'b1; tx_ok = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_ok = 1'b0;
    check("R8 stray done counter", tx_frame_cnt, 0);
    check("R8 stray done irq", irq_buf_chg, 0);
    check_status("R8 stray done");

    // R8: a completion before acceptance is ignored.
    write_prio(16'h0050);
    send_cmd(4'b0010, 1'b1, 1'b0, 1'b0);
    exp_st[1] = 1;
    while (!tx_valid) @(negedge clk);
    tx_done = 1'b1; tx_ok = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_ok = 1'b0;
    check("R8 early done counter", tx_frame_cnt, 0);
    check("R8 early done irq", irq_buf_chg, 0);
    check_status("R8 early done");
    serve(1, 1'b1, 1'b0);
    // R11: completion wins over a coincident abort+release.
    write_prio(16'h0007);
    send_cmd(4'b0001, 1'b1, 1'b0, 1'b0);
    exp_st[0] = 1;
    serve(0, 1'b0, 1'b1);
    write_prio(16'h0);

    // R6: disabled controller issues nothing.
    send_cmd(4'b0100, 1'b1, 1'b0, 1'b0);
    exp_st[2] = 1;
    enable = 1'b0;
    write_prio(16'h0700);
    repeat (5) @(negedge clk);
    check("R6 no request while disabled", tx_valid, 0);
    enable = 1'b1;
    serve(2, 1'b1, 1'b0);
    write_prio(16'h0);

    // R3/R4: every reachable state against every action mix.
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 5; s++)
        for (int c = 0; c < 8; c++) begin
          drive_to(b, s);
          enable = 1'b0;
          send_cmd(4'hF, c[0], c[1], c[2]);
          enable = 1'b1;
          check_status("R3 disabled command");
          send_cmd(4'(1 << b), c[0], c[1], c[2]);
          exp_st[b] = next_st(s, c[0], c[1], c[2]);
          check_status("R4 transition R3 select");
        end

    // R5/R6/R10: serving order over many priority words.
    for (int p = 0; p < 4096; p += 5) begin
      logic [15:0] pw;
      int win;
      send_cmd(4'hF, 1'b0, 1'b1, 1'b1);
      write_prio(16'h0);
      send_cmd(4'hF, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < NB; i++) exp_st[i] = 1;
      pw = '0;
      for (int i = 0; i < NB; i++) begin
        pw[i*4 +: 3] = 3'(p >> (3*i));
        pw[i*4 + 3]  = p[i];
      end
      write_prio(pw);
      win = model_pick();
      while (win >= 0) begin
        serve(win, 1'b1, 1'b0);
        win = model_pick();
      end
      repeat (3) @(negedge clk);
      check("R6 R10 no further request", tx_valid, 0);
      check_status("R6 zero priority left ready");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule